// File: doc/BRIEF.md
# Flash Sector Erase Command Sequencer

This block sits on the write side of a NOR-style flash array and decodes bus write cycles, each one an address, a data byte and a single-cycle write strobe. It accepts the six-write sector erase sequence, gathers one or more sectors into a selection bitmap while a retriggerable acceptance window is open, and then runs a counter-based erase engine over the selected sectors, lowest index first. The same sequence with a different final byte starts a whole-array erase instead.

While the erase runs, the block reports busy and a window-expired flag. It also tells the read path whether a given read address falls in a sector that is being erased, so that reads there return status and all other reads return array data. A suspend command freezes the engine, and a later resume continues it from where it stopped. Inside the window, any unexpected command drops the whole batch.

Top module: `fsec_erase_seq`

## Requirements
- R1: After reset, busy, win_expired and suspended are 0 and erase_set is all zero.
- R2: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h at any address set bit addr[11:9] of erase_set, raise busy and keep win_expired at 0.
- R3: If any of the six writes has the wrong address or data, the sequencer returns to read mode. When the rest of the sequence is then written, it leaves busy at 0 and erase_set at zero.
- R4: win_expired stays 0 for WIN_CYCLES-1 cycles after the last accepted 30h write and rises on the following edge. A 30h write adds its sector and restarts the window, and a write that lands on the final window edge is still accepted.
- R5: Inside the window, any write whose data is neither 30h nor B0h clears erase_set and drops busy on that edge.
- R6: After expiry, each selected sector takes ERASE_CYCLES cycles and sectors are cleared lowest index first. When the last sector clears, busy, win_expired and erase_set return to 0.
- R7: During a sector erase, every write other than B0h has no effect on erase_set or on the completion time.
- R8: B0h written in the window or during a sector erase sets suspended, clears busy, sets win_expired and freezes erase_set and progress. A 30h write then resumes, and the remaining time is preserved.
- R9: 10h@555h as the sixth write selects all sectors, sets win_expired at once with no window, ignores every write including B0h, and ends after NUM_SECT*ERASE_CYCLES cycles.
- R10: rd_sel is 1 exactly when the sector addr[11:9] of rd_addr is set in erase_set.
- R11: Asserting reset during an erase returns the block to read mode with an empty erase_set.
- R12: If B0h arrives on the same edge as the completion of the last sector, the completion wins and the block is not suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, aborts any erase |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data / command byte |
| rd_addr | input | ADDR_W | Read address under test |
| rd_sel | output | 1 | Read address lies in a sector selected for erase |
| busy | output | 1 | Window open or erase running |
| win_expired | output | 1 | Acceptance window over, erase started |
| suspended | output | 1 | Erase suspended |
| erase_set | output | NUM_SECT | Sectors still pending erase |

## Verification
Two pairs of events can land on the same edge. The first pair is a late sector command and window expiry. The bench provokes it by placing a 30h write exactly WIN_CYCLES edges after the previous one, and it judges the result by checking that the new sector joined the set and win_expired is still 0. Moving the write one edge later must leave the set unchanged. The second pair is a suspend command and the completion of the last sector. The bench times B0h to hit the final engine edge and expects busy 0, suspended 0 and an empty set.

// File: rtl/fses_pkg.sv
package fses_pkg;
  typedef enum logic [3:0] {
    ST_READ, ST_UL1, ST_UL2, ST_SETUP, ST_UL3, ST_UL4,
    ST_WINDOW, ST_ERASE, ST_CHIP, ST_SUSP
  } fses_state_e;

  localparam logic [11:0] ADR_KEY_A = 12'h555;
  localparam logic [11:0] ADR_KEY_B = 12'h2AA;
  localparam logic [7:0]  DAT_KEY_A = 8'hAA;
  localparam logic [7:0]  DAT_KEY_B = 8'h55;
  localparam logic [7:0]  DAT_SETUP = 8'h80;
  localparam logic [7:0]  DAT_SECT  = 8'h30;
  localparam logic [7:0]  DAT_CHIP  = 8'h10;
  localparam logic [7:0]  DAT_SUSP  = 8'hB0;
endpackage

// File: rtl/fses_cmd_decode.sv
module fses_cmd_decode #(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output logic              key_a,
  output logic              key_b,
  output logic              setup,
  output logic              sect_cmd,
  output logic              chip_cmd,
  output logic              susp_cmd
);
  import fses_pkg::*;
  logic at_a, at_b;
  assign at_a     = (addr == ADDR_W'(ADR_KEY_A));
  assign at_b     = (addr == ADDR_W'(ADR_KEY_B));
  assign key_a    = at_a && (data == DAT_KEY_A);
  assign key_b    = at_b && (data == DAT_KEY_B);
  assign setup    = at_a && (data == DAT_SETUP);
  assign sect_cmd = (data == DAT_SECT);
  assign chip_cmd = at_a && (data == DAT_CHIP);
  assign susp_cmd = (data == DAT_SUSP);
endmodule

// File: rtl/fses_win_timer.sv
module fses_win_timer #(
  parameter int WIN_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(WIN_CYCLES + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    left_q <= '0;
    else if (load)                 left_q <= CW'(WIN_CYCLES - 1);
    else if (run && left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign expire = run && (left_q == '0);
endmodule

// File: rtl/fses_erase_engine.sv
module fses_erase_engine #(
  parameter int NUM_SECT     = 8,
  parameter int ERASE_CYCLES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                fill,
  input  logic                add_en,
  input  logic [NUM_SECT-1:0] add_mask,
  input  logic                active,
  output logic [NUM_SECT-1:0] pending,
  output logic                sect_done,
  output logic                finish
);
  localparam int ECW = $clog2(ERASE_CYCLES + 1);
  logic [ECW-1:0] ecnt_q;

  function automatic logic [NUM_SECT-1:0] drop_lowest(input logic [NUM_SECT-1:0] m);
    return m & (m - 1'b1);
  endfunction

  assign sect_done = active && (ecnt_q == ECW'(ERASE_CYCLES - 1)) && (pending != '0);
  assign finish    = sect_done && (drop_lowest(pending) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      ecnt_q  <= '0;
    end else if (clear) begin
      pending <= '0;
      ecnt_q  <= '0;
    end else if (fill) begin
      pending <= '1;
      ecnt_q  <= '0;
    end else if (add_en) begin
      pending <= pending | add_mask;
    end else if (active) begin
      if (sect_done) begin
        pending <= drop_lowest(pending);
        ecnt_q  <= '0;
      end else begin
        ecnt_q  <= ecnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsec_erase_seq.sv
module fsec_erase_seq #(
  parameter int ADDR_W       = 12,
  parameter int NUM_SECT     = 8,
  parameter int WIN_CYCLES   = 16,
  parameter int ERASE_CYCLES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic                rd_sel,
  output logic                busy,
  output logic                win_expired,
  output logic                suspended,
  output logic [NUM_SECT-1:0] erase_set
);
  import fses_pkg::*;
  localparam int SECT_W = $clog2(NUM_SECT);

  function automatic logic [NUM_SECT-1:0] sect_bit(input logic [ADDR_W-1:0] a);
    return NUM_SECT'(1) << a[ADDR_W-1 -: SECT_W];
  endfunction

  fses_state_e st_q, st_d;
  logic key_a, key_b, setup, sect_cmd, chip_cmd, susp_cmd;
  logic tmr_exp, sect_done, erase_fin;

  // named internal events
  logic                sect_accept, chip_start, abort_evt, susp_evt;
  logic                resume_evt, win_expire_evt, eng_active;
  logic [NUM_SECT-1:0] sect_onehot;

  fses_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(wr_addr), .data(wr_data),
    .key_a(key_a), .key_b(key_b), .setup(setup),
    .sect_cmd(sect_cmd), .chip_cmd(chip_cmd), .susp_cmd(susp_cmd)
  );

  assign sect_onehot    = sect_bit(wr_addr);
  assign sect_accept    = wr_en && sect_cmd && (st_q == ST_UL4 || st_q == ST_WINDOW);
  assign chip_start     = wr_en && chip_cmd && (st_q == ST_UL4);
  assign abort_evt      = wr_en && (st_q == ST_WINDOW) && !sect_cmd && !susp_cmd;
  assign susp_evt       = wr_en && susp_cmd &&
                          ((st_q == ST_WINDOW) || (st_q == ST_ERASE && !erase_fin));
  assign resume_evt     = wr_en && sect_cmd && (st_q == ST_SUSP);
  assign win_expire_evt = (st_q == ST_WINDOW) && !wr_en && tmr_exp;
  assign eng_active     = (st_q == ST_ERASE) || (st_q == ST_CHIP);

  fses_win_timer #(.WIN_CYCLES(WIN_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(sect_accept),
    .run(st_q == ST_WINDOW), .expire(tmr_exp)
  );

  fses_erase_engine #(.NUM_SECT(NUM_SECT), .ERASE_CYCLES(ERASE_CYCLES)) u_eng (
    .clk(clk), .rst_n(rst_n), .clear(abort_evt), .fill(chip_start),
    .add_en(sect_accept), .add_mask(sect_onehot), .active(eng_active),
    .pending(erase_set), .sect_done(sect_done), .finish(erase_fin)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_READ:   if (wr_en && key_a) st_d = ST_UL1;
      ST_UL1:    if (wr_en) st_d = key_b ? ST_UL2   : ST_READ;
      ST_UL2:    if (wr_en) st_d = setup ? ST_SETUP : ST_READ;
      ST_SETUP:  if (wr_en) st_d = key_a ? ST_UL3   : ST_READ;
      ST_UL3:    if (wr_en) st_d = key_b ? ST_UL4   : ST_READ;
      ST_UL4: begin
        if (sect_accept)     st_d = ST_WINDOW;
        else if (chip_start) st_d = ST_CHIP;
        else if (wr_en)      st_d = ST_READ;
      end
      ST_WINDOW: begin
        if (susp_evt)            st_d = ST_SUSP;
        else if (abort_evt)      st_d = ST_READ;
        else if (win_expire_evt) st_d = ST_ERASE;
      end
      ST_ERASE: begin
        if (erase_fin)     st_d = ST_READ;
        else if (susp_evt) st_d = ST_SUSP;
      end
      ST_CHIP:   if (erase_fin)  st_d = ST_READ;
      ST_SUSP:   if (resume_evt) st_d = ST_ERASE;
      default:   st_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_READ;
    else        st_q <= st_d;
  end

  assign busy        = (st_q == ST_WINDOW) || (st_q == ST_ERASE) || (st_q == ST_CHIP);
  assign win_expired = (st_q == ST_ERASE) || (st_q == ST_CHIP) || (st_q == ST_SUSP);
  assign suspended   = (st_q == ST_SUSP);
  assign rd_sel      = |(erase_set & sect_bit(rd_addr));
endmodule

// File: rtl/fses_checker.sv
module fses_checker #(
  parameter int NUM_SECT = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                win_expired,
  input logic                suspended,
  input logic [NUM_SECT-1:0] erase_set,
  input logic                sect_accept,
  input logic [NUM_SECT-1:0] sect_onehot,
  input logic                abort_evt,
  input logic                chip_start,
  input logic                susp_evt,
  input logic                win_expire_evt,
  input logic                erase_fin,
  input logic                sect_done
);
  a_r2_sector_joins: assert property (@(posedge clk) disable iff (!rst_n)
    sect_accept |=> ((erase_set & $past(sect_onehot)) == $past(sect_onehot)) && busy);

  a_r4_expiry_starts: assert property (@(posedge clk) disable iff (!rst_n)
    win_expire_evt |=> win_expired && busy && !suspended);

  a_r5_abort_empties: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (erase_set == '0) && !busy);

  a_r6_finish_read: assert property (@(posedge clk) disable iff (!rst_n)
    erase_fin |=> !busy && !win_expired && (erase_set == '0));

  a_r7_set_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && win_expired && !sect_done) |=> $stable(erase_set));

  a_r8_suspend_enter: assert property (@(posedge clk) disable iff (!rst_n)
    susp_evt |=> suspended && !busy && win_expired);

  a_r8_suspend_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |=> $stable(erase_set));

  a_r9_chip_all: assert property (@(posedge clk) disable iff (!rst_n)
    chip_start |=> (&erase_set) && win_expired && busy);

  a_r12_finish_wins: assert property (@(posedge clk) disable iff (!rst_n)
    erase_fin |=> !suspended);
endmodule

bind fsec_erase_seq fses_checker #(.NUM_SECT(NUM_SECT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .win_expired(win_expired),
  .suspended(suspended), .erase_set(erase_set), .sect_accept(sect_accept),
  .sect_onehot(sect_onehot), .abort_evt(abort_evt), .chip_start(chip_start),
  .susp_evt(susp_evt), .win_expire_evt(win_expire_evt),
  .erase_fin(erase_fin), .sect_done(sect_done)
);

// File: tb/fsec_erase_seq_test.sv
module fsec_erase_seq_test;
  localparam int AW = 12, NS = 8, W = 16, EC = 8;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic rd_sel, busy, win_expired, suspended;
  logic [NS-1:0] erase_set;
  int n_pass = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fsec_erase_seq #(.ADDR_W(AW), .NUM_SECT(NS), .WIN_CYCLES(W), .ERASE_CYCLES(EC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_sel(rd_sel), .busy(busy), .win_expired(win_expired),
    .suspended(suspended), .erase_set(erase_set)
  );

  function automatic logic [AW-1:0] sa(input int s, input int off);
    return {s[2:0], off[8:0]};
  endfunction
  function automatic logic [NS-1:0] minus_first(input logic [NS-1:0] m);
    for (int i = 0; i < NS; i++) if (m[i]) begin m[i] = 1'b0; return m; end
    return m;
  endfunction
  function automatic int pop(input logic [NS-1:0] m);
    int c = 0;
    for (int i = 0; i < NS; i++) c += m[i];
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    if (act === exp) n_pass++;
    else begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic prefix();
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55);
  endtask

  // wait out the window from the last accepted write (R4)
  task automatic expire_window();
    for (int t = 1; t <= W; t++) begin
      @(negedge clk);
      if (t == W - 1) check("R4 still open", {busy, win_expired}, 2'b10);
      if (t == W)     check("R4 expired", {busy, win_expired}, 2'b11);
    end
  endtask

  // called right after expiry; runs the erase of mask to completion (R6)
  task automatic run_erase(input logic [NS-1:0] mask, input int already);
    int total = pop(mask) * EC - already;
    for (int t = 1; t <= total; t++) begin
      @(negedge clk);
      if (already == 0 && t == EC - 1) check("R6 first sector pending", erase_set, mask);
      if (already == 0 && t == EC)     check("R6 lowest first", erase_set, minus_first(mask));
      if (t == total - 1) check("R6 busy before end", busy, 1'b1);
      if (t == total)
        check("R6 back to read", {busy, win_expired, suspended, erase_set}, '0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h5EC7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", {busy, win_expired, suspended, erase_set}, '0);

    // R2 / R10 / R4 boundary: write on the final window edge still joins
    prefix(); wr(sa(2, 17), 8'h30);
    check("R2 sector set", {busy, win_expired, erase_set}, {2'b10, 8'h04});
    repeat (W - 2) @(negedge clk);
    wr(sa(6, 3), 8'h30);
    check("R4 last-edge write accepted", {win_expired, erase_set}, {1'b0, 8'h44});
    rd_addr = sa(6, 99); #1 check("R10 selected read", rd_sel, 1'b1);
    rd_addr = sa(3, 99); #1 check("R10 unselected read", rd_sel, 1'b0);
    expire_window();
    run_erase(8'h44, 0);

    // R4: one edge too late is ignored; R7 erase continues unchanged
    prefix(); wr(sa(2, 0), 8'h30);
    repeat (W - 1) @(negedge clk);
    wr(sa(6, 0), 8'h30);
    check("R4 late write ignored", {win_expired, erase_set}, {1'b1, 8'h04});
    repeat (EC - 2) @(negedge clk);
    check("R7 busy to end", busy, 1'b1);
    @(negedge clk);
    check("R7 finished on time", {busy, erase_set}, '0);

    // R7: stray writes during erase
    prefix(); wr(sa(5, 1), 8'h30); expire_window();
    wr(sa(1, 0), 8'h30); wr(12'h555, 8'hAA);
    check("R7 set unchanged", erase_set, 8'h20);
    repeat (EC - 5) @(negedge clk);
    check("R7 still busy", busy, 1'b1);
    @(negedge clk);
    check("R7 done on time", busy, 1'b0);

    // R5: abort inside the window
    prefix(); wr(sa(3, 5), 8'h30); wr(sa(4, 5), 8'h30); wr(12'h555, 8'hAA);
    check("R5 abort", {busy, erase_set}, '0);
    prefix(); wr(sa(0, 1), 8'h30); wr(12'h000, 8'hF0);
    check("R5 abort reset cmd", {busy, win_expired, erase_set}, '0);

    // R8: suspend during erase, resume keeps remaining time
    prefix(); wr(sa(1, 0), 8'h30); wr(sa(4, 0), 8'h30); expire_window();
    repeat (3) @(negedge clk);
    wr(12'h000, 8'hB0);
    check("R8 suspended", {suspended, busy, win_expired, erase_set}, {3'b101, 8'h12});
    repeat (10) @(negedge clk);
    wr(sa(7, 0), 8'hF0);
    check("R8 frozen", {suspended, erase_set}, {1'b1, 8'h12});
    wr(12'h000, 8'h30);
    check("R8 resumed", {suspended, busy}, 2'b01);
    run_erase(8'h12, 5);

    // R8: suspend inside the window
    prefix(); wr(sa(3, 0), 8'h30); wr(12'h000, 8'hB0);
    check("R8 window suspend", {suspended, busy, win_expired, erase_set}, {3'b101, 8'h08});
    wr(12'h000, 8'h30);
    run_erase(8'h08, 0);

    // R12: suspend on completion edge
    prefix(); wr(sa(0, 0), 8'h30); expire_window();
    repeat (EC - 2) @(negedge clk);
    wr(12'h000, 8'hB0);
    check("R12 completion wins", {suspended, busy, erase_set}, '0);

    // R9: chip erase
    prefix(); wr(12'h555, 8'h10);
    check("R9 chip start", {busy, win_expired, erase_set}, {2'b11, 8'hFF});
    wr(12'h000, 8'hB0); wr(12'h555, 8'hAA);
    check("R9 writes ignored", {suspended, erase_set}, {1'b0, 8'hFF});
    repeat (NS * EC - 5) @(negedge clk);
    check("R9 still busy", busy, 1'b1);
    @(negedge clk);
    check("R9 chip done", {busy, win_expired, erase_set}, '0);

    // R11: reset mid-erase
    prefix(); wr(sa(6, 0), 8'h30); expire_window();
    repeat (3) @(negedge clk);
    do_reset();
    check("R11 reset aborts", {busy, win_expired, suspended, erase_set}, '0);

    // R3: random corruption of one cycle
    for (int k = 0; k < 12; k++) begin
      logic [AW-1:0] a [6];
      logic [7:0] d [6];
      int bad = $urandom_range(0, 5);
      a = '{12'h555, 12'h2AA, 12'h555, 12'h555, 12'h2AA, sa($urandom_range(0, 7), 0)};
      d = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h30};
      if ($urandom_range(0, 1) == 0) d[bad] = d[bad] ^ 8'h01;
      else if (bad < 5) a[bad] = a[bad] ^ 12'h001;
      else d[bad] = 8'hA0;
      for (int i = 0; i < 6; i++) wr(a[i], d[i]);
      check("R3 mismatch to read", {busy, erase_set}, '0);
    end

    // R2 / R4 / R6: random batches
    for (int k = 0; k < 6; k++) begin
      logic [NS-1:0] m = '0;
      int n = $urandom_range(1, 4);
      prefix();
      for (int i = 0; i < n; i++) begin
        int s = $urandom_range(0, NS - 1);
        if (i > 0) repeat ($urandom_range(0, W - 2)) @(negedge clk);
        wr(sa(s, $urandom_range(0, 511)), 8'h30);
        m[s] = 1'b1;
        check("R2 batch grows", erase_set, m);
      end
      expire_window();
      run_erase(m, 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
      $finish;
    end
  end
endmodule